// File: doc/BRIEF.md
# Dual-Mode Magnitude Comparator

This block compares two operands of a parameterised width and reports whether the first is greater than, equal to or less than the second. A single mode input selects how the operands are read. When it is low, they are plain unsigned binaries. When it is high, they are two's-complement signed values. The block is purely combinational: the flags follow the inputs with no clock and no state.

Both modes use one unsigned comparator over the bits below the most significant bit. A small decision stage looks at the two top bits and the mode. When the top bits differ, that stage alone fixes the answer, and the direction depends on the mode. When the top bits match, the stage passes on the result of the shared low comparator. This works unchanged for two negative operands, because their low bits rise in the same order as their values. The block therefore has no second comparator and no mode multiplexer across two full results.

Top module: `magcmp_dual`

## Requirements
- R1: With `signed_mode` = 0 and equal top bits, the flags give the unsigned ordering of the full operands.
- R2: With `signed_mode` = 1 and different top bits (bit WIDTH-1), the operand whose top bit is 0 is reported as greater.
- R3: With `signed_mode` = 1 and equal top bits, the flags give the unsigned ordering of the low WIDTH-1 bits, and this matches the two's-complement ordering, including when both operands are negative.
- R4: `a_eq` is 1 exactly when all WIDTH bits of the two operands match, in either mode.
- R5: Exactly one of `a_gt`, `a_eq` and `a_lt` is 1 for every input combination.
- R6: When the top bits are equal, toggling `signed_mode` leaves all three flags unchanged.
- R7: With `signed_mode` = 0 and different top bits, the operand whose top bit is 1 is reported as greater.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| op_a | input | WIDTH | First operand |
| op_b | input | WIDTH | Second operand |
| signed_mode | input | 1 | 1 = two's-complement signed, 0 = unsigned |
| a_gt | output | 1 | op_a greater than op_b |
| a_eq | output | 1 | op_a equal to op_b |
| a_lt | output | 1 | op_a less than op_b |

## Verification
Every pair of 4-bit operands is applied in both modes. Each result is compared with the ordering the bench computes from native unsigned and signed arithmetic. Pairs with different top bits separate the two mode-specific decisions from each other. Pairs with the same top bit, including pairs of negative values, test the shared low comparator on its own. Applying each pair in both modes also confirms that the mode changes nothing when the top bits agree.

// File: rtl/magcmp_pkg.sv
package magcmp_pkg;
  typedef enum logic {
    MODE_UNSIGNED = 1'b0,
    MODE_SIGNED   = 1'b1
  } cmp_mode_e;

  typedef struct packed {
    logic gt;
    logic eq;
    logic lt;
  } cmp_flags_t;
endpackage

// File: rtl/magcmp_low.sv
// Unsigned comparator over the low bits, shared by both modes.
module magcmp_low #(
  parameter int W = 3
) (
  input  logic [W-1:0] lo_a,
  input  logic [W-1:0] lo_b,
  output logic         lo_gt,
  output logic         lo_lt
);
  // Decision ripples from the top bit downward; the first differing bit wins.
  logic [W:0] gt_c;
  logic [W:0] lt_c;

  assign gt_c[W] = 1'b0;
  assign lt_c[W] = 1'b0;

  for (genvar i = W - 1; i >= 0; i--) begin : g_bit
    logic decided;
    assign decided = gt_c[i+1] | lt_c[i+1];
    assign gt_c[i] = gt_c[i+1] | (~decided & lo_a[i] & ~lo_b[i]);
    assign lt_c[i] = lt_c[i+1] | (~decided & ~lo_a[i] & lo_b[i]);
  end

  assign lo_gt = gt_c[0];
  assign lo_lt = lt_c[0];
endmodule

// File: rtl/magcmp_msb.sv
// Mode-specific handling of the top bit.
module magcmp_msb
  import magcmp_pkg::*;
(
  input  logic       top_a,
  input  logic       top_b,
  input  cmp_mode_e  mode,
  input  logic       lo_gt,
  input  logic       lo_lt,
  output cmp_flags_t flags
);
  logic top_differ;
  logic a_wins_top;

  assign top_differ = top_a ^ top_b;
  // Unsigned: a top bit of 1 is larger. Signed: a top bit of 0 is larger.
  assign a_wins_top = (mode == MODE_SIGNED) ? ~top_a : top_a;

  always_comb begin
    if (top_differ) begin
      flags.gt = a_wins_top;
      flags.lt = ~a_wins_top;
      flags.eq = 1'b0;
    end else begin
      flags.gt = lo_gt;
      flags.lt = lo_lt;
      flags.eq = ~lo_gt & ~lo_lt;
    end
  end
endmodule

// File: rtl/magcmp_dual.sv
module magcmp_dual
  import magcmp_pkg::*;
#(
  parameter int WIDTH = 4
) (
  input  logic [WIDTH-1:0] op_a,
  input  logic [WIDTH-1:0] op_b,
  input  logic             signed_mode,
  output logic             a_gt,
  output logic             a_eq,
  output logic             a_lt
);
  localparam int LOW_W = WIDTH - 1;

  logic       low_gt;
  logic       low_lt;
  cmp_flags_t res;
  cmp_mode_e  mode;

  assign mode = cmp_mode_e'(signed_mode);

  magcmp_low #(.W(LOW_W)) u_low (
    .lo_a  (op_a[LOW_W-1:0]),
    .lo_b  (op_b[LOW_W-1:0]),
    .lo_gt (low_gt),
    .lo_lt (low_lt)
  );

  magcmp_msb u_msb (
    .top_a (op_a[WIDTH-1]),
    .top_b (op_b[WIDTH-1]),
    .mode  (mode),
    .lo_gt (low_gt),
    .lo_lt (low_lt),
    .flags (res)
  );

  assign a_gt = res.gt;
  assign a_eq = res.eq;
  assign a_lt = res.lt;
endmodule

// File: rtl/magcmp_dual_chk.sv
module magcmp_dual_chk #(
  parameter int WIDTH = 4
) (
  input logic [WIDTH-1:0] op_a,
  input logic [WIDTH-1:0] op_b,
  input logic             signed_mode,
  input logic             a_gt,
  input logic             a_eq,
  input logic             a_lt
);
  always_comb begin
    assert_one_flag_R5: assert ($countones({a_gt, a_eq, a_lt}) == 1)
      else $error("R5 flags not one-hot");
    assert_eq_full_R4: assert (a_eq == (op_a == op_b))
      else $error("R4 equal flag mismatch");
    if (!signed_mode && (op_a[WIDTH-1] == op_b[WIDTH-1])) begin
      assert_unsigned_R1: assert (a_gt == (op_a > op_b))
        else $error("R1 unsigned ordering");
    end
    if (!signed_mode && (op_a[WIDTH-1] != op_b[WIDTH-1])) begin
      assert_unsigned_top_R7: assert (a_gt == op_a[WIDTH-1])
        else $error("R7 unsigned top bit");
    end
    if (signed_mode && (op_a[WIDTH-1] != op_b[WIDTH-1])) begin
      assert_signed_top_R2: assert (a_gt == !op_a[WIDTH-1])
        else $error("R2 signed top bit");
    end
    if (signed_mode && (op_a[WIDTH-1] == op_b[WIDTH-1])) begin
      assert_signed_low_R3: assert (a_lt == ($signed(op_a) < $signed(op_b)))
        else $error("R3 signed ordering");
    end
  end
endmodule

bind magcmp_dual magcmp_dual_chk #(.WIDTH(WIDTH)) u_chk (
  .op_a        (op_a),
  .op_b        (op_b),
  .signed_mode (signed_mode),
  .a_gt        (a_gt),
  .a_eq        (a_eq),
  .a_lt        (a_lt)
);

// File: tb/magcmp_dual_bench.sv
module magcmp_dual_bench;
  localparam int CLK_PERIOD = 10;
  localparam int W = 4;

  logic         clk = 1'b0;
  logic [W-1:0] op_a = '0;
  logic [W-1:0] op_b = '0;
  logic         signed_mode = 1'b0;
  logic         a_gt, a_eq, a_lt;
  int           n_tests = 0;
  int           n_fail = 0;
  bit           done = 1'b0;

  always #(CLK_PERIOD/2) clk = ~clk;

  magcmp_dual #(.WIDTH(W)) u_magcmp_dual (
    .op_a(op_a), .op_b(op_b), .signed_mode(signed_mode),
    .a_gt(a_gt), .a_eq(a_eq), .a_lt(a_lt)
  );

  task automatic check(input string req, input logic [2:0] act, input logic [2:0] exp);
    n_tests++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s a=%0h b=%0h mode=%0b actual=%b expected=%b",
               req, op_a, op_b, signed_mode, act, exp);
    end
  endtask

  task automatic apply(input logic [W-1:0] a, input logic [W-1:0] b, input logic m);
    @(posedge clk);
    op_a = a; op_b = b; signed_mode = m;
    #(CLK_PERIOD/2);
  endtask

  initial begin
    // Initial state: both operands zero, unsigned -> equal
    apply('0, '0, 1'b0);
    check("R4", {a_gt, a_eq, a_lt}, 3'b010);
    for (int ia = 0; ia < (1 << W); ia++) begin
      for (int ib = 0; ib < (1 << W); ib++) begin
        logic [W-1:0] va, vb;
        logic [2:0]   exp_u, exp_s, got_u, got_s;
        logic         same_top;
        va = W'(ia); vb = W'(ib);
        same_top = (va[W-1] == vb[W-1]);
        exp_u = {va > vb, va == vb, va < vb};
        exp_s = {$signed(va) > $signed(vb), va == vb, $signed(va) < $signed(vb)};

        apply(va, vb, 1'b0);
        got_u = {a_gt, a_eq, a_lt};
        check(same_top ? "R1" : "R7", got_u, exp_u);
        check("R5", {2'b00, ($countones(got_u) == 1)}, 3'b001);
        check("R4", {2'b00, got_u[1]}, {2'b00, va == vb});

        apply(va, vb, 1'b1);
        got_s = {a_gt, a_eq, a_lt};
        check(same_top ? "R3" : "R2", got_s, exp_s);
        check("R5", {2'b00, ($countones(got_s) == 1)}, 3'b001);
        check("R4", {2'b00, got_s[1]}, {2'b00, va == vb});
        if (same_top) check("R6", got_s, got_u);
      end
    end
    // Negative pairs called out explicitly: -1 > -4 > -7
    apply(4'hF, 4'hC, 1'b1);
    check("R3", {a_gt, a_eq, a_lt}, 3'b100);
    apply(4'h9, 4'hC, 1'b1);
    check("R3", {a_gt, a_eq, a_lt}, 3'b001);
    done = 1'b1;
    $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
    $finish;
  end

  initial begin
    #(CLK_PERIOD * 20000);
    if (!done) begin
      n_tests++;
      n_fail++;
      $display("FAIL watchdog actual=timeout expected=completion");
      $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
      $finish;
    end
  end
endmodule